// File: doc/BRIEF.md
# Shared-Timer Input Debouncer

This block filters a bank of input pins against contact bounce and short glitches. Instead of giving every pin its own debounce counter, it keeps a small pool of three programmable period timers. Each pin chooses one of them, or none, through a 2-bit index. Any number of pins may use the same timer. The filtered pins drive downstream logic such as edge or level interrupt detection.

Configuration is a simple write port. Three addresses load the timer periods, counted in clock cycles. Two more addresses hold the pin indices as two bit-planes: one register holds the upper index bit of every pin, and the other holds the lower index bit. Index zero bypasses the filter. A pin that is not marked input-capable by a build-time mask always stays in bypass.

Every pin passes through a two-stage synchronizer first. A filtered pin changes its output only when its timer has ticked twice in a row and the synchronized level was the same at both ticks.

Top module: `shared_debounce_bank`

## Requirements
- R1: After reset, all periods and selector bits are zero and every pin is in bypass. pin_out then equals pin_in delayed by two clock cycles.
- R2: A pin with index 0 drives pin_out from its synchronized input with no added delay: an input change appears exactly two cycles later.
- R3: Addresses 0, 1 and 2 load the periods of timers 1, 2 and 3. A timer with period P > 0 ticks once every P cycles. A timer with period 0 never ticks, so its pins keep their outputs frozen.
- R4: A pin's index is {upper, lower}. The upper bit is bit i of the register at address 4 and the lower bit is bit i of the register at address 5, where bit i belongs to pin i. Index values 1, 2 and 3 select timers 1, 2 and 3.
- R5: A filtered pin updates pin_out only on a tick of its selected timer, and only when the synchronized input at that tick equals the input sampled at the previous tick.
- R6: Any number of pins may select the same timer at once, and each pin is filtered independently.
- R7: Writing a period restarts that timer. With period P > 1, the first tick comes P cycles after the write edge, and there is no tick in the cycle right after the write.
- R8: A write that changes a pin's index discards that pin's pending sample. The pin then needs two fresh ticks before pin_out can change.
- R9: Selector bits of pins that are clear in the parameter CAP_MASK are forced to zero, so those pins stay in bypass whatever is written.
- R10: Writes to addresses 3, 6 and 7 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Register select: 0-2 periods, 4 upper index bits, 5 lower index bits |
| cfg_wdata | input | PERIOD_W (32) | Write data |
| pin_in | input | NUM_PINS (32) | Raw asynchronous pin levels |
| pin_out | output | NUM_PINS (32) | Debounced or bypassed pin levels |

## Verification
The assertions check on every cycle that a timer stays silent after a restart and between ticks, and that a filtered output never moves without a tick of its timer. They also check that a first sample after a discard never moves the output, and that pins outside CAP_MASK never hold a non-zero selector. Only the bench's scenarios show the full filtering result: glitch rejection under fast-toggling inputs, sharing of one timer by many pins, frozen outputs with a zero period, and the exact cycle in which output changes occur after period rewrites and index changes. The bench checks these against a behavioural model on every clock.

// File: rtl/dbnc_pkg.sv
// Shared constants for the shared-timer debouncer.
// Assumes exactly three timers, because the pin index is two bits wide.
package dbnc_pkg;
    localparam int unsigned NUM_TIMERS = 3;
    localparam int unsigned IDX_W      = 2;
    localparam int unsigned ADDR_W     = 3;

    localparam logic [ADDR_W-1:0] A_PER1  = 3'd0;
    localparam logic [ADDR_W-1:0] A_PER2  = 3'd1;
    localparam logic [ADDR_W-1:0] A_PER3  = 3'd2;
    localparam logic [ADDR_W-1:0] A_SELHI = 3'd4;
    localparam logic [ADDR_W-1:0] A_SELLO = 3'd5;
endpackage

// File: rtl/dbnc_tick_timer.sv
// Free-running period timer.
// Counts down and emits a one-cycle tick each time the count reaches zero, so
// period P gives one tick every P cycles. Period 0 never ticks. A load writes a
// new period and restarts the count.
module dbnc_tick_timer #(
    parameter int unsigned PERIOD_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic [PERIOD_W-1:0] load_val,
    output logic                tick
);
    logic [PERIOD_W-1:0] period_q;
    logic [PERIOD_W-1:0] cnt_q;

    // Tick when the count is exhausted on an enabled timer.
    assign tick = (period_q != '0) && (cnt_q == '0);

    // Period register and down-counter with restart on load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            period_q <= '0;
            cnt_q    <= '0;
        end else if (load) begin
            period_q <= load_val;
            cnt_q    <= (load_val == '0) ? '0 : load_val - 1'b1;
        end else if (tick) begin
            cnt_q <= period_q - 1'b1;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assert_tick_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load && period_q > 1) |=> !tick);
    assert_restart_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (load && load_val > 1) |=> !tick);
endmodule

// File: rtl/dbnc_sync.sv
// Multi-stage synchronizer for a vector of asynchronous pins.
// Assumes each bit is an independent level and needs no bus coherence.
module dbnc_sync #(
    parameter int unsigned WIDTH  = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [STAGES-1:0][WIDTH-1:0] stg_q;

    // Shift the pin levels through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) stg_q[0] <= '0;
        else        stg_q[0] <= d;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        // One further synchronizer stage.
        always_ff @(posedge clk) begin
            if (!rst_n) stg_q[s] <= '0;
            else        stg_q[s] <= stg_q[s-1];
        end
    end

    assign q = stg_q[STAGES-1];
endmodule

// File: rtl/dbnc_pin_filter.sv
// Per-pin two-tick agreement filter.
// Assumes din is already synchronized. With index 0 the pin is bypassed and the
// held level tracks din. Otherwise the held level takes din only when two
// consecutive ticks of the selected timer saw the same value. clr discards the
// pending sample.
module dbnc_pin_filter #(
    parameter int unsigned NT = dbnc_pkg::NUM_TIMERS
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NT-1:0]             tick,
    input  logic [dbnc_pkg::IDX_W-1:0] idx,
    input  logic                      clr,
    input  logic                      din,
    output logic                      dout
);
    logic filt_q, samp_q, valid_q, sel_tick;

    // Pick the tick of the selected timer; none in bypass.
    always_comb begin
        sel_tick = 1'b0;
        if (idx != '0) sel_tick = tick[idx - 1'b1];
    end

    // Sample on ticks and commit a level after two agreeing samples.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            filt_q  <= 1'b0;
            samp_q  <= 1'b0;
            valid_q <= 1'b0;
        end else if (idx == '0) begin
            filt_q  <= din;
            valid_q <= 1'b0;
        end else if (clr) begin
            valid_q <= 1'b0;
        end else if (sel_tick) begin
            if (valid_q && (din == samp_q)) filt_q <= din;
            samp_q  <= din;
            valid_q <= 1'b1;
        end
    end

    assign dout = (idx == '0) ? din : filt_q;

    assert_hold_between_ticks_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (idx != '0 && !sel_tick) |=> $stable(filt_q));
    assert_first_sample_no_commit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (idx != '0 && !valid_q) |=> $stable(filt_q));
    assert_discard_on_change_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (idx != '0 && clr) |=> !valid_q);
endmodule

// File: rtl/shared_debounce_bank.sv
// Debouncer for a bank of input pins that share three programmable period timers.
// Holds the period registers and the two selector bit-planes, synchronizes the
// pins, and filters each pin using the tick of its chosen timer. Assumes the
// NUM_PINS <= PERIOD_W and CAP_MASK marks the input-capable pins.
module shared_debounce_bank #(
    parameter int unsigned   NUM_PINS    = 32,
    parameter int unsigned   PERIOD_W    = 32,
    parameter int unsigned   SYNC_STAGES = 2,
    parameter logic [31:0]   CAP_MASK    = 32'hFFFF_FFFF
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cfg_we,
    input  logic [dbnc_pkg::ADDR_W-1:0] cfg_addr,
    input  logic [PERIOD_W-1:0]         cfg_wdata,
    input  logic [NUM_PINS-1:0]         pin_in,
    output logic [NUM_PINS-1:0]         pin_out
);
    import dbnc_pkg::*;

    localparam logic [NUM_PINS-1:0] CAP = CAP_MASK[NUM_PINS-1:0];

    logic [NUM_PINS-1:0]   sel_hi_q, sel_lo_q, sel_hi_d, sel_lo_d;
    logic [NUM_PINS-1:0]   pin_sync, idx_clr;
    logic [NUM_TIMERS-1:0] tick;
    logic                  we_hi, we_lo;

    assign we_hi    = cfg_we && (cfg_addr == A_SELHI);
    assign we_lo    = cfg_we && (cfg_addr == A_SELLO);
    assign sel_hi_d = we_hi ? (cfg_wdata[NUM_PINS-1:0] & CAP) : sel_hi_q;
    assign sel_lo_d = we_lo ? (cfg_wdata[NUM_PINS-1:0] & CAP) : sel_lo_q;
    assign idx_clr  = (sel_hi_d ^ sel_hi_q) | (sel_lo_d ^ sel_lo_q);

    // Selector bit-planes: upper and lower index bit of every pin.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_hi_q <= '0;
            sel_lo_q <= '0;
        end else begin
            sel_hi_q <= sel_hi_d;
            sel_lo_q <= sel_lo_d;
        end
    end

    for (genvar t = 0; t < NUM_TIMERS; t++) begin : g_timer
        dbnc_tick_timer #(.PERIOD_W(PERIOD_W)) u_tmr (
            .clk     (clk),
            .rst_n   (rst_n),
            .load    (cfg_we && (cfg_addr == ADDR_W'(t))),
            .load_val(cfg_wdata),
            .tick    (tick[t])
        );
    end

    dbnc_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (pin_in),
        .q    (pin_sync)
    );

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        dbnc_pin_filter #(.NT(NUM_TIMERS)) u_flt (
            .clk  (clk),
            .rst_n(rst_n),
            .tick (tick),
            .idx  ({sel_hi_q[i], sel_lo_q[i]}),
            .clr  (idx_clr[i]),
            .din  (pin_sync[i]),
            .dout (pin_out[i])
        );
    end

    assert_capable_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((sel_hi_q | sel_lo_q) & ~CAP) == '0);
    assert_reserved_addr_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr == 3'd3) |=> ($stable(sel_hi_q) && $stable(sel_lo_q)));
endmodule

// File: tb/sim_shared_debounce_bank.sv
module sim_shared_debounce_bank;
    localparam logic [31:0] CAP = 32'hFFFF_FF0F;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] pin_in = '0;
    logic [31:0] pin_out;

    always #5 clk = ~clk;

    shared_debounce_bank #(.CAP_MASK(CAP)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .pin_in(pin_in), .pin_out(pin_out)
    );

    int checks = 0;
    int failures = 0;
    string cur_req = "R1";
    bit cmp_on = 1'b0;

    // Behavioural reference state.
    logic [31:0] m_per [3];
    logic [31:0] m_cnt [3];
    logic [31:0] m_hi, m_lo, m_s1, m_s2, m_f, m_samp, m_val;

    function automatic logic [31:0] model_out();
        logic [31:0] r;
        for (int i = 0; i < 32; i++)
            r[i] = ({m_hi[i], m_lo[i]} == 2'd0) ? m_s2[i] : m_f[i];
        return r;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int t = 0; t < 3; t++) begin m_per[t] = '0; m_cnt[t] = '0; end
            m_hi = '0; m_lo = '0; m_s1 = '0; m_s2 = '0; m_f = '0; m_samp = '0; m_val = '0;
        end else begin
            bit tk [3];
            for (int t = 0; t < 3; t++) tk[t] = (m_per[t] != 0) && (m_cnt[t] == 0);
            for (int i = 0; i < 32; i++) begin
                int ix;
                bit chg;
                ix = {m_hi[i], m_lo[i]};
                chg = cfg_we && ((cfg_addr == 4 && (cfg_wdata[i] & CAP[i]) != m_hi[i]) ||
                                 (cfg_addr == 5 && (cfg_wdata[i] & CAP[i]) != m_lo[i]));
                if (ix == 0) begin
                    m_f[i] = m_s2[i]; m_val[i] = 1'b0;
                end else if (chg) begin
                    m_val[i] = 1'b0;
                end else if (tk[ix-1]) begin
                    if (m_val[i] && m_s2[i] == m_samp[i]) m_f[i] = m_s2[i];
                    m_samp[i] = m_s2[i]; m_val[i] = 1'b1;
                end
            end
            for (int t = 0; t < 3; t++) begin
                if (cfg_we && cfg_addr == 3'(t)) begin
                    m_per[t] = cfg_wdata;
                    m_cnt[t] = (cfg_wdata == 0) ? 32'd0 : cfg_wdata - 1;
                end else if (tk[t]) m_cnt[t] = m_per[t] - 1;
                else if (m_cnt[t] != 0) m_cnt[t] = m_cnt[t] - 1;
            end
            if (cfg_we && cfg_addr == 4) m_hi = cfg_wdata & CAP;
            if (cfg_we && cfg_addr == 5) m_lo = cfg_wdata & CAP;
            m_s2 = m_s1; m_s1 = pin_in;
        end
    end

    // Per-cycle comparison against the reference, away from the active edge.
    always @(negedge clk) begin
        if (cmp_on && rst_n) begin
            logic [31:0] e;
            e = model_out();
            checks++;
            if (pin_out !== e) begin
                failures++;
                $display("FAIL %s cycle-compare: pin_out=%h expected=%h", cur_req, pin_out, e);
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s directed: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk); cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk); cfg_we = 1'b0;
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] held;
        // R1: reset state, then bypass of an all-ones input.
        pin_in = 32'hFFFF_FFFF;
        step(3);
        @(negedge clk); rst_n = 1'b1;
        check("R1", pin_out, 32'h0);
        step(1);
        check("R1", pin_out, 32'h0);
        step(1);
        check("R1", pin_out, 32'hFFFF_FFFF);
        cmp_on = 1'b1;

        // R2: bypass latency is exactly two cycles.
        cur_req = "R2";
        pin_in = 32'hA5A5_5A5A;
        step(1); check("R2", pin_out, 32'hFFFF_FFFF);
        step(1); check("R2", pin_out, 32'hA5A5_5A5A);
        for (int k = 0; k < 20; k++) begin @(negedge clk); pin_in = $urandom; end

        // R3/R4/R9: periods 4, 7, 0; pins 0-7 idx1, 8-15 idx2, 16-23 idx3, 24-31 bypass.
        cur_req = "R4";
        wr(3'd0, 32'd4); wr(3'd1, 32'd7); wr(3'd2, 32'd0);
        wr(3'd4, 32'h00FF_FF00);
        wr(3'd5, 32'h00FF_00FF);
        step(4);
        held = pin_out;
        pin_in = ~pin_in;
        step(60);
        check("R3", pin_out & 32'h00FF_0000, held & 32'h00FF_0000);
        check("R9", pin_out & 32'h0000_00F0, pin_in & 32'h0000_00F0);

        // R5/R6: slow and glitchy stimulus on pins sharing timers.
        cur_req = "R6";
        for (int k = 0; k < 25; k++) begin @(negedge clk); pin_in = $urandom; step(12); end
        cur_req = "R5";
        for (int k = 0; k < 200; k++) begin @(negedge clk); pin_in = $urandom; end
        held = pin_in;
        step(30);
        check("R5", pin_out & 32'h0000_FF0F, held & 32'h0000_FF0F);

        // R7: period rewrites restart timers mid-run.
        cur_req = "R7";
        for (int k = 0; k < 6; k++) begin
            pin_in = $urandom;
            wr(3'd0, 32'(3 + k));
            step(5 + k);
            wr(3'd1, 32'(1 + k));
            step(9);
        end

        // R8: repeated index changes discard pending samples.
        cur_req = "R8";
        wr(3'd2, 32'd2);
        for (int k = 0; k < 10; k++) begin
            pin_in = $urandom;
            step(3);
            wr(3'd4, $urandom);
            step(2);
            pin_in = $urandom;
            wr(3'd5, $urandom);
            step(7);
        end

        // R10: writes to reserved addresses leave all state unchanged.
        cur_req = "R10";
        wr(3'd4, 32'h0F0F_F0F0); wr(3'd5, 32'h3333_3333);
        step(10);
        wr(3'd3, 32'hFFFF_FFFF); wr(3'd6, 32'h0); wr(3'd7, 32'hFFFF_FFFF);
        for (int k = 0; k < 40; k++) begin @(negedge clk); pin_in = $urandom; end
        step(20);

        cmp_on = 1'b0;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule